// File: doc/BRIEF.md
# Area-Configurable External Bus Controller

This block turns single read and write requests from an internal processor port into timed cycles on an external parallel bus. The 24-bit external address range is split into eight equal areas selected by the three most significant address bits. Two 8-bit configuration registers give each area its own data bus width (8 or 16 bits) and its own cycle timing: two states, or three states with the external wait input honoured.

When a request is accepted, the block looks up the target area and fixes the width and timing for the whole transaction. It then steps through the bus states, drives address, strobes and write data, and captures read data. A 16-bit request aimed at an 8-bit area runs as two byte cycles that are merged into one response. A single `rsp_done` pulse marks the end of each request. The register reset value for the width register comes from a two-bit boot mode input.

Top module: `ext_bus_ctrl`

## Requirements
- R1: `cfg_sel`=0 addresses the width register and `cfg_sel`=1 the timing register. A write with `cfg_we` loads all 8 bits of the addressed register and leaves the other one unchanged. `cfg_rdata` shows the addressed register combinationally.
- R2: During synchronous reset (`rst_n`=0) the timing register becomes 8'hFF. The width register becomes 8'hFF when `boot_mode` is 2'b01 or 2'b10, and 8'h00 when it is 2'b00 or 2'b11. After reset `req_ready`=1 and every strobe is high.
- R3: The target area is `req_addr[23:21]`, and bit n of each register controls area n. While any strobe is low, `ext_addr[23:21]` equals the requested area.
- R4: If the area's timing bit is 0, each byte cycle lasts two clock states and `ext_wait` is ignored. A single-cycle request raises `rsp_done` after the second clock edge following the accept edge.
- R5: If the area's timing bit is 1, each byte cycle lasts three states. `ext_wait` is sampled at the end of the second state, and one extra state is inserted for each edge at which it is high. With no wait, `rsp_done` follows the third edge after acceptance.
- R6: If the width bit is 1 (8-bit area), a 16-bit request runs as two back-to-back byte cycles. The first cycle uses the even address (bit 0 cleared) and carries the high byte. The second uses address+1 and carries the low byte. A read returns {first, second} with a single `rsp_done`.
- R7: If the width bit is 0 (16-bit area), a 16-bit access uses both lanes with address bit 0 cleared. A byte access at an even address uses the upper lane `[15:8]` and `ext_hwr_n`. A byte access at an odd address uses the lower lane `[7:0]` and `ext_lwr_n`. Byte write data comes from `req_wdata[7:0]`, and byte reads return in `rsp_rdata[7:0]` with the upper byte zero.
- R8: An 8-bit area moves every byte on the upper lane `[15:8]` and strobes only `ext_hwr_n`. `ext_lwr_n` stays high.
- R9: `ext_rd_n` is low in every state of a read cycle. Write strobes are low in every state of a byte cycle except its first. Read and write strobes are never low together.
- R10: A register write changes only requests accepted after it. A write on the same edge that accepts a request does not affect that request.
- R11: `req_ready` is high only when idle, and a request is accepted on an edge where `req_valid` and `req_ready` are both high. `rsp_done` is a one-cycle pulse, and `rsp_rdata` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 2 | Selects the reset value of the width register |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_sel | input | 1 | 0: width register, 1: timing register |
| cfg_wdata | input | 8 | Configuration write data, bit n for area n |
| cfg_rdata | output | 8 | Contents of the addressed configuration register |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_word | input | 1 | 1: 16-bit access, 0: byte access |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 16 | Write data (byte writes use [7:0]) |
| req_ready | output | 1 | Idle and able to accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| ext_addr | output | 24 | External address, zero when idle |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_hwr_n | output | 1 | Upper-lane write strobe, active low |
| ext_lwr_n | output | 1 | Lower-lane write strobe, active low |
| ext_doe | output | 1 | Write data output enable |
| ext_dout | output | 16 | Write data lanes |
| ext_din | input | 16 | Read data lanes |
| ext_wait | input | 1 | Wait request, active high |

## Verification
A configuration write and the acceptance of a request can land on the same clock edge. The register updates on that edge, while the sequencer latches the area settings from the same edge. The bench issues a timing-register write on the exact edge that accepts a split read in a slow 8-bit area, and a width-register write in the middle of a later request. Correct behaviour is judged by measuring the state count and read data of both the affected request and the one after it: the first must keep the old cycle shape, and the second must show the new one.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
// Package ebc_pkg
// Shared types and helpers for the external bus controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ebc_pkg;

    // Bus state of the cycle sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3
    } bus_state_e;

    // True when the boot mode selects an all-ones width reset value.
    function automatic logic narrow_reset_all(input logic [1:0] mode);
        return (mode == 2'b01) || (mode == 2'b10);
    endfunction

endpackage

// File: rtl/ebc_cfg_regs.sv
`timescale 1ns/1ps
// Module ebc_cfg_regs
// Holds the per-area width and timing registers and provides readback.
// Assumes: boot_mode is stable while rst_n is low; one register per write.
module ebc_cfg_regs
    import ebc_pkg::*;
#(
    parameter int NUM_AREAS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           boot_mode,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [NUM_AREAS-1:0] cfg_wdata,
    output logic [NUM_AREAS-1:0] cfg_rdata,
    output logic [NUM_AREAS-1:0] width_q,
    output logic [NUM_AREAS-1:0] timing_q
);

    // Register update: mode-dependent reset for width, all-ones for timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= narrow_reset_all(boot_mode) ? '1 : '0;
            timing_q <= '1;
        end else if (cfg_we) begin
            if (cfg_sel) timing_q <= cfg_wdata;
            else         width_q  <= cfg_wdata;
        end
    end

    // Readback multiplexer.
    always_comb begin
        cfg_rdata = cfg_sel ? timing_q : width_q;
    end

endmodule

// File: rtl/ebc_area_decode.sv
`timescale 1ns/1ps
// Module ebc_area_decode
// Turns the area field of an address into a one-hot hit vector and picks
// that area's width and timing bits.
// Assumes: NUM_AREAS equals 2**AREA_BITS.
module ebc_area_decode #(
    parameter int AREA_BITS = 3,
    parameter int NUM_AREAS = 8
) (
    input  logic [AREA_BITS-1:0] area,
    input  logic [NUM_AREAS-1:0] width_cfg,
    input  logic [NUM_AREAS-1:0] timing_cfg,
    output logic                 area_narrow,
    output logic                 area_slow
);

    logic [NUM_AREAS-1:0] hit;

    // One comparator per area.
    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_hit
        assign hit[g] = (area == AREA_BITS'(g));
    end

    // AND-OR select of the configuration bits for the hit area.
    always_comb begin
        area_narrow = |(hit & width_cfg);
        area_slow   = |(hit & timing_cfg);
    end

endmodule

// File: rtl/ebc_data_steer.sv
`timescale 1ns/1ps
// Module ebc_data_steer
// Chooses data lanes and lane strobes for the current byte cycle and picks
// the read byte from the right lane.
// Assumes: byte write data sits in wdata[BYTE_W-1:0]; split words send the
// high byte first.
module ebc_data_steer #(
    parameter int DATA_W = 16
) (
    input  logic                  narrow,
    input  logic                  is_word,
    input  logic                  second,
    input  logic                  addr_lsb,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     dout,
    output logic                  hi_lane,
    output logic                  lo_lane,
    output logic [DATA_W/2-1:0]   rbyte
);

    localparam int BYTE_W = DATA_W / 2;

    // Lane selection for writes and reads.
    always_comb begin
        dout    = '0;
        hi_lane = 1'b0;
        lo_lane = 1'b0;
        rbyte   = din[DATA_W-1:BYTE_W];
        if (narrow) begin
            hi_lane = 1'b1;
            if (is_word && !second) dout[DATA_W-1:BYTE_W] = wdata[DATA_W-1:BYTE_W];
            else                    dout[DATA_W-1:BYTE_W] = wdata[BYTE_W-1:0];
        end else if (is_word) begin
            dout    = wdata;
            hi_lane = 1'b1;
            lo_lane = 1'b1;
        end else if (addr_lsb) begin
            lo_lane            = 1'b1;
            dout[BYTE_W-1:0]   = wdata[BYTE_W-1:0];
            rbyte              = din[BYTE_W-1:0];
        end else begin
            hi_lane               = 1'b1;
            dout[DATA_W-1:BYTE_W] = wdata[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/ebc_sequencer.sv
`timescale 1ns/1ps
// Module ebc_sequencer
// Accepts one request at a time, latches the area settings, steps the bus
// states (T1, T2, optional waits, T3), splits words for 8-bit areas and
// assembles the response.
// Assumes: area_narrow/area_slow already decoded from req_addr.
module ebc_sequencer
    import ebc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_word,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                area_narrow,
    input  logic                area_slow,
    input  logic                ext_wait,
    input  logic [DATA_W-1:0]   ext_din,
    input  logic [DATA_W/2-1:0] rbyte,
    output logic                req_ready,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                busy,
    output logic                wr_phase,
    output logic                in_wait,
    output logic [ADDR_W-1:0]   cyc_addr,
    output logic                cyc_write,
    output logic                cyc_word,
    output logic                cyc_narrow,
    output logic                cyc_slow,
    output logic                cyc_second,
    output logic [DATA_W-1:0]   cyc_wdata
);

    localparam int BYTE_W = DATA_W / 2;

    bus_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [BYTE_W-1:0] first_q;
    logic              final_st;
    logic              split;

    // Last state of a byte cycle, and whether the request needs two cycles.
    always_comb begin
        final_st = ((state_q == ST_T2) && !cyc_slow) || (state_q == ST_T3);
        split    = cyc_word && cyc_narrow;
    end

    // State machine, request latch and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            first_q    <= '0;
            cyc_write  <= 1'b0;
            cyc_word   <= 1'b0;
            cyc_narrow <= 1'b0;
            cyc_slow   <= 1'b0;
            cyc_second <= 1'b0;
            cyc_wdata  <= '0;
            rsp_done   <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q    <= ST_T1;
                        cyc_write  <= req_write;
                        cyc_word   <= req_word;
                        cyc_narrow <= area_narrow;
                        cyc_slow   <= area_slow;
                        cyc_second <= 1'b0;
                        cyc_wdata  <= req_wdata;
                        base_q     <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
                    end
                end
                ST_T1: state_q <= ST_T2;
                ST_T2: begin
                    if (cyc_slow) state_q <= ext_wait ? ST_TW : ST_T3;
                end
                ST_TW: begin
                    if (!ext_wait) state_q <= ST_T3;
                end
                ST_T3: state_q <= ST_T3;
                default: state_q <= ST_IDLE;
            endcase
            if (final_st) begin
                if (split && !cyc_second) begin
                    cyc_second <= 1'b1;
                    first_q    <= rbyte;
                    state_q    <= ST_T1;
                end else begin
                    state_q  <= ST_IDLE;
                    rsp_done <= 1'b1;
                    if (!cyc_word)      rsp_rdata <= {{BYTE_W{1'b0}}, rbyte};
                    else if (cyc_narrow) rsp_rdata <= {first_q, rbyte};
                    else                 rsp_rdata <= ext_din;
                end
            end
        end
    end

    // Status and address of the current byte cycle.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = !req_ready;
        wr_phase  = busy && (state_q != ST_T1);
        in_wait   = (state_q == ST_TW);
        cyc_addr  = {base_q[ADDR_W-1:1], base_q[0] | cyc_second};
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
`timescale 1ns/1ps
// Module ext_bus_ctrl
// Top of the area-configurable external bus controller: configuration
// registers, area decode, cycle sequencer and lane steering.
// Assumes: requests are held until req_ready; ext_din is valid by the end of
// each final bus state.
module ext_bus_ctrl #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int AREA_BITS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              boot_mode,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [2**AREA_BITS-1:0] cfg_wdata,
    output logic [2**AREA_BITS-1:0] cfg_rdata,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_word,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ready,
    output logic                    rsp_done,
    output logic [DATA_W-1:0]       rsp_rdata,
    output logic [ADDR_W-1:0]       ext_addr,
    output logic                    ext_rd_n,
    output logic                    ext_hwr_n,
    output logic                    ext_lwr_n,
    output logic                    ext_doe,
    output logic [DATA_W-1:0]       ext_dout,
    input  logic [DATA_W-1:0]       ext_din,
    input  logic                    ext_wait
);

    localparam int NUM_AREAS = 2 ** AREA_BITS;
    localparam int BYTE_W    = DATA_W / 2;

    logic [NUM_AREAS-1:0] width_q;
    logic [NUM_AREAS-1:0] timing_q;
    logic                 area_narrow;
    logic                 area_slow;
    logic                 busy;
    logic                 wr_phase;
    logic                 in_wait;
    logic [ADDR_W-1:0]    cyc_addr;
    logic                 cyc_write;
    logic                 cyc_word;
    logic                 cyc_narrow;
    logic                 cyc_slow;
    logic                 cyc_second;
    logic [DATA_W-1:0]    cyc_wdata;
    logic [DATA_W-1:0]    steer_dout;
    logic                 hi_lane;
    logic                 lo_lane;
    logic [BYTE_W-1:0]    rbyte;

    ebc_cfg_regs #(.NUM_AREAS(NUM_AREAS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .width_q   (width_q),
        .timing_q  (timing_q)
    );

    ebc_area_decode #(.AREA_BITS(AREA_BITS), .NUM_AREAS(NUM_AREAS)) u_decode (
        .area        (req_addr[ADDR_W-1 -: AREA_BITS]),
        .width_cfg   (width_q),
        .timing_cfg  (timing_q),
        .area_narrow (area_narrow),
        .area_slow   (area_slow)
    );

    ebc_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_word    (req_word),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .area_narrow (area_narrow),
        .area_slow   (area_slow),
        .ext_wait    (ext_wait),
        .ext_din     (ext_din),
        .rbyte       (rbyte),
        .req_ready   (req_ready),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .busy        (busy),
        .wr_phase    (wr_phase),
        .in_wait     (in_wait),
        .cyc_addr    (cyc_addr),
        .cyc_write   (cyc_write),
        .cyc_word    (cyc_word),
        .cyc_narrow  (cyc_narrow),
        .cyc_slow    (cyc_slow),
        .cyc_second  (cyc_second),
        .cyc_wdata   (cyc_wdata)
    );

    ebc_data_steer #(.DATA_W(DATA_W)) u_steer (
        .narrow   (cyc_narrow),
        .is_word  (cyc_word),
        .second   (cyc_second),
        .addr_lsb (cyc_addr[0]),
        .wdata    (cyc_wdata),
        .din      (ext_din),
        .dout     (steer_dout),
        .hi_lane  (hi_lane),
        .lo_lane  (lo_lane),
        .rbyte    (rbyte)
    );

    // External pin drive derived from sequencer state and lane choice.
    always_comb begin
        ext_addr  = busy ? cyc_addr : '0;
        ext_rd_n  = !(busy && !cyc_write);
        ext_hwr_n = !(cyc_write && wr_phase && hi_lane);
        ext_lwr_n = !(cyc_write && wr_phase && lo_lane);
        ext_doe   = busy && cyc_write;
        ext_dout  = ext_doe ? steer_dout : '0;
    end

endmodule

// File: rtl/ext_bus_ctrl_chk.sv
`timescale 1ns/1ps
// Module ext_bus_ctrl_chk
// Concurrent property checks for ext_bus_ctrl, attached by bind.
// Assumes: connected to the top's ports and internal state named below.
module ext_bus_ctrl_chk #(
    parameter int NUM_AREAS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_done,
    input logic                 ext_rd_n,
    input logic                 ext_hwr_n,
    input logic                 ext_lwr_n,
    input logic                 cfg_we,
    input logic                 cfg_sel,
    input logic [NUM_AREAS-1:0] cfg_wdata,
    input logic [NUM_AREAS-1:0] width_q,
    input logic [NUM_AREAS-1:0] timing_q,
    input logic                 cyc_narrow,
    input logic                 cyc_slow,
    input logic                 in_wait
);

    a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && (!ext_hwr_n || !ext_lwr_n)));

    a_r8_narrow_no_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_narrow |-> ext_lwr_n);

    a_r4_wait_only_when_slow: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> cyc_slow);

    a_r11_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r11_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ext_rd_n && ext_hwr_n && ext_lwr_n));

    a_r1_width_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (width_q == $past(cfg_wdata)));

    a_r1_timing_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (timing_q == $past(cfg_wdata)));

endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk #(.NUM_AREAS(2 ** AREA_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .ext_rd_n   (ext_rd_n),
    .ext_hwr_n  (ext_hwr_n),
    .ext_lwr_n  (ext_lwr_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .width_q    (width_q),
    .timing_q   (timing_q),
    .cyc_narrow (cyc_narrow),
    .cyc_slow   (cyc_slow),
    .in_wait    (in_wait)
);

// File: tb/ext_bus_ctrl_bench.sv
`timescale 1ns/1ps
// Bench ext_bus_ctrl_bench
// Sweeps every area under four register patterns and all access kinds, then
// wait lengths and configuration-write timing, with arithmetic expectations.
module ext_bus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  boot_mode;
    logic        cfg_we;
    logic        cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        req_valid;
    logic        req_write;
    logic        req_word;
    logic [23:0] req_addr;
    logic [15:0] req_wdata;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [23:0] ext_addr;
    logic        ext_rd_n;
    logic        ext_hwr_n;
    logic        ext_lwr_n;
    logic        ext_doe;
    logic [15:0] ext_dout;
    logic [15:0] ext_din;
    logic        ext_wait;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    // Read data model: a function of the byte address on each lane.
    assign ext_din = {ext_addr[7:0] ^ 8'h5A, ext_addr[7:0] ^ 8'hC3};

    ext_bus_ctrl u_ext_bus_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .ext_addr  (ext_addr),
        .ext_rd_n  (ext_rd_n),
        .ext_hwr_n (ext_hwr_n),
        .ext_lwr_n (ext_lwr_n),
        .ext_doe   (ext_doe),
        .ext_dout  (ext_dout),
        .ext_din   (ext_din),
        .ext_wait  (ext_wait)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic cfg_write(input bit sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_expect(input bit sel, input logic [7:0] exp, input string req);
        cfg_sel = sel;
        #1;
        check(cfg_rdata == exp, req, sel ? "timing readback" : "width readback",
              32'(cfg_rdata), 32'(exp));
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; boot_mode = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: mode-dependent width reset, timing all ones, idle outputs
        cfg_expect(1'b0, ((m == 2'b01) || (m == 2'b10)) ? 8'hFF : 8'h00, "R2");
        cfg_expect(1'b1, 8'hFF, "R2");
        check(req_ready && ext_rd_n && ext_hwr_n && ext_lwr_n, "R2", "idle after reset",
              {28'h0, req_ready, ext_rd_n, ext_hwr_n, ext_lwr_n}, 32'hF);
    endtask

    // One request with full expectation; cfg_at = -1 none, 0 on the accept
    // edge, k>0 at the k-th state after acceptance.
    task automatic do_txn(input int area, input bit wr, input bit word, input logic [7:0] lowb,
                          input int dly, input bit exp_n, input bit exp_s,
                          input int cfg_at, input bit csel, input logic [7:0] cval,
                          output int lat_o);
        logic [7:0]  bm [2];
        logic [7:0]  a_eff;
        logic [15:0] wd, got, exp_rd, exp_bm;
        int n, cnt_rd, cnt_h, cnt_l, bad_area, bad_ready;
        int ncyc, per, w, total, wst, exp_h, exp_l;
        bit done_seen;
        string tl, td;
        bm[0] = 8'h00; bm[1] = 8'h00;
        cnt_rd = 0; cnt_h = 0; cnt_l = 0; bad_area = 0; bad_ready = 0;
        done_seen = 1'b0; got = '0;
        a_eff = word ? {lowb[7:1], 1'b0} : lowb;
        wd = {1'b1, lowb[6:0], lowb[6:0], 1'b1};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = word;
        req_addr = {3'(area), 13'h0, lowb}; req_wdata = wd;
        ext_wait = (dly >= 1);
        if (cfg_at == 0) begin cfg_we = 1'b1; cfg_sel = csel; cfg_wdata = cval; end
        @(posedge clk);
        n = 0;
        while (!done_seen && n <= 80) begin
            @(negedge clk);
            if (n == 0) req_valid = 1'b0;
            if (cfg_at > 0 && n == cfg_at) begin
                cfg_we = 1'b1; cfg_sel = csel; cfg_wdata = cval;
            end else if (cfg_we) begin
                cfg_we = 1'b0;
            end
            ext_wait = (n + 1 <= dly);
            if (rsp_done) begin
                got = rsp_rdata;
                done_seen = 1'b1;
            end else begin
                if (!ext_rd_n) cnt_rd++;
                if (!ext_hwr_n) begin
                    cnt_h++;
                    if (exp_n) bm[ext_addr[0]] = ext_dout[15:8];
                    else       bm[0] = ext_dout[15:8];
                end
                if (!ext_lwr_n) begin
                    cnt_l++;
                    bm[1] = ext_dout[7:0];
                end
                if ((!ext_rd_n || !ext_hwr_n || !ext_lwr_n) && ext_addr[23:21] != 3'(area))
                    bad_area++;
                if (req_ready) bad_ready++;
                @(posedge clk);
                n++;
            end
        end
        ext_wait = 1'b0;
        lat_o = n;
        ncyc  = (word && exp_n) ? 2 : 1;
        per   = exp_s ? 3 : 2;
        w     = (exp_s && dly >= 2) ? dly - 1 : 0;
        total = ncyc * per + w;
        tl = (word && exp_n) ? "R6" : (exp_s ? "R5" : "R4");
        td = exp_n ? (word ? "R6" : "R8") : "R7";
        check(done_seen && n == total, tl, "states to done", 32'(n), 32'(total));
        check(bad_area == 0, "R3", "area bits on bus", 32'(bad_area), 32'h0);
        check(bad_ready == 0, "R11", "ready while busy", 32'(bad_ready), 32'h0);
        if (!wr) begin
            if (word && exp_n)  exp_rd = {a_eff ^ 8'h5A, (a_eff | 8'h01) ^ 8'h5A};
            else if (word)      exp_rd = {a_eff ^ 8'h5A, a_eff ^ 8'hC3};
            else if (exp_n || !lowb[0]) exp_rd = {8'h00, lowb ^ 8'h5A};
            else                exp_rd = {8'h00, lowb ^ 8'hC3};
            check(got == exp_rd, td, "read data", 32'(got), 32'(exp_rd));
            check(cnt_rd == total, "R9", "read strobe states", 32'(cnt_rd), 32'(total));
            check(cnt_h + cnt_l == 0, "R9", "write strobe in read", 32'(cnt_h + cnt_l), 32'h0);
        end else begin
            wst = total - ncyc;
            if (exp_n)                  begin exp_h = wst; exp_l = 0;   end
            else if (word)              begin exp_h = wst; exp_l = wst; end
            else if (lowb[0])           begin exp_h = 0;   exp_l = wst; end
            else                        begin exp_h = wst; exp_l = 0;   end
            exp_bm = word ? wd : (lowb[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00});
            check({bm[0], bm[1]} == exp_bm, td, "written bytes", 32'({bm[0], bm[1]}), 32'(exp_bm));
            check(cnt_rd == 0, "R9", "read strobe in write", 32'(cnt_rd), 32'h0);
            check(cnt_h == exp_h, "R9", "upper write strobe states", 32'(cnt_h), 32'(exp_h));
            check(cnt_l == exp_l, exp_n ? "R8" : "R7", "lower write strobe states",
                  32'(cnt_l), 32'(exp_l));
        end
        @(negedge clk);
        check(!rsp_done, "R11", "done lasts one cycle", 32'(rsp_done), 32'h0);
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog expired: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int lat;
        logic [7:0] wp, tp, lowb;
        rst_n = 1'b0; boot_mode = 2'b00; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0; req_addr = '0; req_wdata = '0;
        ext_wait = 1'b0;

        for (int m = 0; m < 4; m++) do_reset(2'(m));

        // R1: each register written independently and read back
        cfg_write(1'b0, 8'h3B);
        cfg_expect(1'b0, 8'h3B, "R1");
        cfg_expect(1'b1, 8'hFF, "R1");
        cfg_write(1'b1, 8'hC4);
        cfg_expect(1'b1, 8'hC4, "R1");
        cfg_expect(1'b0, 8'h3B, "R1");

        // Sweep: four pattern pairs give every area all four settings
        for (int p = 0; p < 4; p++) begin
            wp = p[0] ? 8'h69 : 8'h96;
            tp = p[1] ? 8'hA3 : 8'h5C;
            cfg_write(1'b0, wp);
            cfg_write(1'b1, tp);
            cfg_expect(1'b0, wp, "R1");
            cfg_expect(1'b1, tp, "R1");
            for (int area = 0; area < 8; area++) begin
                for (int op = 0; op < 6; op++) begin
                    lowb = 8'(area * 29 + op * 6 + p * 50);
                    lowb[0] = ((op % 3) != 0);
                    do_txn(area, op >= 3, (op % 3) == 2, lowb, 0, wp[area], tp[area],
                           -1, 1'b0, 8'h00, lat);
                end
            end
        end

        // R5 / R4: wait lengths in a slow area, ignored in a fast area
        cfg_write(1'b0, 8'h00);
        cfg_write(1'b1, 8'h01);
        for (int d = 0; d < 6; d++) begin
            do_txn(0, 1'b0, 1'b0, 8'h40, d, 1'b0, 1'b1, -1, 1'b0, 8'h00, lat);
        end
        do_txn(0, 1'b1, 1'b1, 8'h44, 3, 1'b0, 1'b1, -1, 1'b0, 8'h00, lat);
        do_txn(1, 1'b0, 1'b0, 8'h41, 4, 1'b0, 1'b0, -1, 1'b0, 8'h00, lat);
        check(lat == 2, "R4", "wait ignored in two-state area", 32'(lat), 32'd2);
        do_txn(1, 1'b1, 1'b0, 8'h42, 4, 1'b0, 1'b0, -1, 1'b0, 8'h00, lat);

        // R10: write on the accept edge keeps old settings for that request
        cfg_write(1'b0, 8'hFF);
        cfg_write(1'b1, 8'hFF);
        do_txn(2, 1'b0, 1'b1, 8'h20, 0, 1'b1, 1'b1, 0, 1'b1, 8'h00, lat);
        check(lat == 6, "R10", "same-edge write left request unchanged", 32'(lat), 32'd6);
        do_txn(2, 1'b0, 1'b1, 8'h22, 0, 1'b1, 1'b0, -1, 1'b0, 8'h00, lat);
        check(lat == 4, "R10", "next request uses new timing", 32'(lat), 32'd4);
        // R10: width change in mid-request leaves the split in place
        do_txn(2, 1'b1, 1'b1, 8'h24, 0, 1'b1, 1'b0, 1, 1'b0, 8'h00, lat);
        check(lat == 4, "R10", "mid-request write ignored", 32'(lat), 32'd4);
        do_txn(2, 1'b1, 1'b1, 8'h26, 0, 1'b0, 1'b0, -1, 1'b0, 8'h00, lat);
        check(lat == 2, "R10", "next request uses new width", 32'(lat), 32'd2);

        summary();
        $finish;
    end

endmodule